// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is a memory-mapped general-purpose I/O port of up to 32 pins. Software reaches it through a plain 32-bit register interface (byte-offset address, write enable, write data, combinational read data). For each pin it keeps the value to drive, whether the pin is an input or an output, whether the driven value should blink, and whether the sampled input should be inverted. It drives the pad data and pad enable lines and takes the pad input level through a two-flop synchronizer.

The sampled input, after the per-pin inversion, can be read back as a read-only register. The same vector is exported on a port so that a separate interrupt block can use it. A free-running divider makes a square wave that blinking output pins follow. Pins at or above the configured pin count do not exist: they read as zero, drive nothing and ignore writes.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset every implemented pin is an input (its direction bit is 1), the drive value, blink and inversion registers are 0, and every `pad_oe` bit is 0.
- R2: `reg_addr[4:2]` picks the register and `reg_addr[1:0]` is ignored: 0 = drive value (0x00), 1 = direction (0x04), 2 = blink enable (0x08), 3 = input inversion (0x0C), 4 = input data (0x10). Codes 5 to 7 read as 0, and writes to them change no register.
- R3: A write with `wr_en` high updates the selected register at that clock edge. `rd_data` shows the selected register combinationally.
- R4: `pad_oe[i]` is 1 exactly when pin i is implemented and its direction bit is 0.
- R5: A pin whose blink bit is 0 drives its drive-value bit on `pad_out`.
- R6: A divider alternates a phase that is low for BLINK_HALF cycles and then high for BLINK_HALF cycles. A pin with its blink bit set drives 0 while the phase is low and drives its drive-value bit while the phase is high.
- R7: The input data register reads as the pad level XOR the inversion register, bit by bit. A pad change shows up after two clock edges and not after one.
- R8: `in_adj` carries the same inverted and synchronized vector as the input data register.
- R9: The input data register is read-only. A write to offset 0x10 changes no register and no output.
- R10: Bits at or above NUM_PINS read as 0 in every register, ignore writes, and stay 0 on `pad_out`, `pad_oe` and `in_adj`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad drive value |
| pad_oe | output | 32 | Pad drive enable |
| in_adj | output | 32 | Synchronized, inverted input vector for the interrupt block |

## Verification
The bench looks at the synchronizer latency one edge at a time. A design with one flop, or with the inversion applied before the flops, would show the new level after one edge or would show it late. It writes to the read-only offset and to unused offsets and then reads back every register; an address decode that aliases these would corrupt the drive value or the direction. It counts the cycles a blinking pin spends high over two full divider periods, so a wrong half-period or a phase that is inverted changes the count. It writes all ones and checks that no bit above the pin count shows up on any port.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    SEL_DRIVE = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_BLINK = 3'd2,
    SEL_INV   = 3'd3,
    SEL_INDAT = 3'd4
  } reg_sel_e;

  // mask of implemented pins
  function automatic logic [REG_W-1:0] pin_mask(input int n);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (i < n);
    return m;
  endfunction

  // per-pin pad value: blinking pins are gated by the divider phase
  function automatic logic [REG_W-1:0] blink_drive(input logic [REG_W-1:0] drv,
                                                    input logic [REG_W-1:0] blk,
                                                    input logic phase);
    return (drv & ~blk) | (drv & blk & {REG_W{phase}});
  endfunction

  function automatic logic [REG_W-1:0] invert_in(input logic [REG_W-1:0] lvl,
                                                  input logic [REG_W-1:0] inv);
    return lvl ^ inv;
  endfunction
endpackage

// File: rtl/gpiob_sync.sv
module gpiob_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpiob_blink_div.sv
module gpiob_blink_div #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      phase <= ~phase;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpiob_regs.sv
module gpiob_regs
  import gpiob_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] drive_q,
  output logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] blink_q,
  output logic [REG_W-1:0] inv_q
);
  localparam logic [REG_W-1:0] MASK = pin_mask(NUM_PINS);

  logic [REG_W-1:0] wd;
  assign wd = wr_data & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      dir_q   <= MASK;
      blink_q <= '0;
      inv_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DRIVE: drive_q <= wd;
        SEL_DIR:   dir_q   <= wd;
        SEL_BLINK: blink_q <= wd;
        SEL_INV:   inv_q   <= wd;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpiob_pkg::*;
#(
  parameter int NUM_PINS   = 24,
  parameter int BLINK_HALF = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [31:0] pad_in,
  output logic [31:0] pad_out,
  output logic [31:0] pad_oe,
  output logic [31:0] in_adj
);
  localparam logic [REG_W-1:0] MASK = pin_mask(NUM_PINS);

  reg_sel_e         sel;
  logic [REG_W-1:0] drive_q, dir_q, blink_q, inv_q;
  logic [REG_W-1:0] pad_sync;
  logic             blink_phase;

  assign sel = reg_sel_e'(reg_addr[4:2]);

  gpiob_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
    .drive_q(drive_q), .dir_q(dir_q), .blink_q(blink_q), .inv_q(inv_q)
  );

  gpiob_sync #(.W(REG_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  gpiob_blink_div #(.HALF(BLINK_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .phase(blink_phase)
  );

  assign in_adj  = invert_in(pad_sync, inv_q) & MASK;
  assign pad_out = blink_drive(drive_q, blink_q, blink_phase) & MASK;
  assign pad_oe  = ~dir_q & MASK;

  always_comb begin
    case (sel)
      SEL_DRIVE: rd_data = drive_q;
      SEL_DIR:   rd_data = dir_q;
      SEL_BLINK: rd_data = blink_q;
      SEL_INV:   rd_data = inv_q;
      SEL_INDAT: rd_data = in_adj;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk
  import gpiob_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_addr,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] pad_in,
  input logic [31:0] pad_out,
  input logic [31:0] pad_oe,
  input logic [31:0] in_adj,
  input logic [31:0] drive_q,
  input logic [31:0] dir_q,
  input logic [31:0] blink_q,
  input logic [31:0] inv_q,
  input logic        blink_phase
);
  localparam logic [31:0] MASK = pin_mask(NUM_PINS);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R4
  dir_write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr[4:2] == 3'd1) |=> (pad_oe == (~$past(wr_data) & MASK)));

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr[4:2] == 3'd4) |=>
      ($stable(drive_q) && $stable(dir_q) && $stable(blink_q) && $stable(inv_q)));

  // R7
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (in_adj == (($past(pad_in, 2) ^ inv_q) & MASK)));

  // R6
  blink_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_phase |-> ((pad_out & blink_q) == 32'd0));

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out | pad_oe | in_adj) & ~MASK) == 32'd0);
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .in_adj(in_adj),
  .drive_q(drive_q), .dir_q(dir_q), .blink_q(blink_q), .inv_q(inv_q),
  .blink_phase(blink_phase)
);

// File: tb/gpio_port_bank_test.sv
module gpio_port_bank_test;
  localparam int PINS = 24;
  localparam int HALF = 6;
  localparam logic [31:0] M = 32'h00FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, pad_out, pad_oe, in_adj;
  logic [31:0] pad_in = '0;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port_bank #(.NUM_PINS(PINS), .BLINK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .in_adj(in_adj)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h00, v); check("R1 drive", v, 32'h0);
    rd(5'h04, v); check("R1 dir", v, M);
    rd(5'h08, v); check("R1 blink", v, 32'h0);
    rd(5'h0C, v); check("R1 inv", v, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(5'h00, 32'h00A5_5A0F);
    wr(5'h08, 32'h0);
    wr(5'h04, 32'h00FF_0000);
    rd(5'h00, v); check("R3 drive readback", v, 32'h00A5_5A0F);
    rd(5'h04, v); check("R3 dir readback", v, 32'h00FF_0000);
    rd(5'h06, v); check("R2 low addr bits ignored", v, 32'h00FF_0000);
    check("R4 pad_oe", pad_oe, 32'h0000_FFFF);
    check("R5 pad_out steady", pad_out, 32'h00A5_5A0F);
  endtask

  task automatic t_input();
    logic [31:0] v;
    wr(5'h0C, 32'h0000_00F0);
    @(negedge clk); pad_in = 32'h0000_0F0F;
    @(negedge clk);
    rd(5'h10, v); check("R7 not after one edge", v, 32'h0000_00F0);
    @(negedge clk);
    rd(5'h10, v); check("R7 after two edges", v, 32'h0000_0FFF);
    check("R8 in_adj", in_adj, 32'h0000_0FFF);
    wr(5'h0C, 32'h0);
    rd(5'h10, v); check("R7 inversion off", v, 32'h0000_0F0F);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h00, v); check("R9 drive kept", v, 32'h00A5_5A0F);
    rd(5'h04, v); check("R9 dir kept", v, 32'h00FF_0000);
    rd(5'h08, v); check("R2 blink kept", v, 32'h0);
    rd(5'h0C, v); check("R9 inv kept", v, 32'h0);
    rd(5'h10, v); check("R9 input unchanged", v, 32'h0000_0F0F);
    rd(5'h18, v); check("R2 unused reads zero", v, 32'h0);
    check("R9 pad_out kept", pad_out, 32'h00A5_5A0F);
  endtask

  task automatic t_upper();
    logic [31:0] v;
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h04, 32'h0);
    wr(5'h0C, 32'hFFFF_FFFF);
    pad_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd(5'h00, v); check("R10 drive upper", v, M);
    rd(5'h0C, v); check("R10 inv upper", v, M);
    check("R10 pad_out", pad_out, M);
    check("R10 pad_oe", pad_oe, M);
    check("R10 in_adj", in_adj, 32'h0);
    pad_in = 32'h0;
    wr(5'h0C, 32'h0);
  endtask

  task automatic t_blink();
    int hi0 = 0, hi1 = 0, hi2 = 0;
    wr(5'h00, 32'h0000_0003);
    wr(5'h08, 32'h0000_0005);
    for (int k = 0; k < 4 * HALF; k++) begin
      @(negedge clk);
      hi0 += pad_out[0];
      hi1 += pad_out[1];
      hi2 += pad_out[2];
    end
    check("R6 blink high count", hi0, 2 * HALF);
    check("R5 steady pin", hi1, 4 * HALF);
    check("R6 blink with drive 0", hi2, 0);
    wr(5'h08, 32'h0);
    check("R5 blink off", pad_out, 32'h0000_0003);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_input();
    t_readonly();
    t_upper();
    t_blink();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule